// File: doc/BRIEF.md
# Wide Synchronous Up/Down Counter Chain

This block builds one wide synchronous counter from a row of narrow counter stages. Each stage is a small binary counter with a shared four-way mode select: parallel preset, count up, count down, or hold. Each stage has active-low carry signals. A registered terminal-count flag drives the stage's carry-out. A second registered flag drives a look-ahead carry-out that pulses one cycle before the stage reaches its terminal value. A look-ahead carry-in is captured in a flop and then combined with the direct carry-in to give the stage's count enable.

The lowest stage has both carry inputs tied active, so it steps on every counting clock. Every upper stage registers the lowest stage's look-ahead pulse. Each upper stage takes its direct carry-in from the carry-out of the stage just below it. The direct carry-ins therefore ripple through the chain without a clock, but they have a full lowest-stage period to settle. The count rate is limited only by one flop-to-flop look-ahead hop. With the default parameters, four 6-bit stages form a 24-bit counter. The outputs are the full count and the active-low carry-out of the top stage.

Top module: `casc_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 and `carry_out_n` is 1.
- R2: With `mode` = 2'b00 at a rising edge, `count` takes the value of `preset` for all stages at once, whatever the carry state.
- R3: With `mode` = 2'b01, `count` rises by one per rising edge, modulo 2^24, across every stage boundary and including the wrap from all ones to zero.
- R4: With `mode` = 2'b10, `count` falls by one per rising edge, modulo 2^24, including the wrap from zero to all ones.
- R5: With `mode` = 2'b11, `count` does not change.
- R6: The lowest stage's look-ahead carry-out is low only while that stage reads 6'b111110 (after counting up) or 6'b000001 (after counting down). When it is low and the mode is up, the lowest stage's carry-out is low on the next cycle.
- R7: Once at least one count edge has passed since the last preset or hold, `carry_out_n` is low exactly while `count` is all ones in up mode, or all zeros in down mode.
- R8: Upper stages step only on the edge where the lowest stage rolls over. For carries to reach them on the first rollover, the lowest 6 bits of a preset must be below 6'b111110 when counting up and above 6'b000001 when counting down.
- R9: `rst_n` is released through a two-flop synchronizer. In up mode, `count` is still 0 after the third rising edge that follows the release, and is 1 after the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 2 | 00 preset, 01 up, 10 down, 11 hold |
| preset | input | 24 | Parallel preset value for all stages |
| count | output | 24 | Full counter value |
| carry_out_n | output | 1 | Active-low carry-out of the top stage |

## Verification
The most likely internal faults are a lost or late look-ahead capture in an upper stage and a stale terminal flag. A lost or late capture leaves the upper 18 bits stepping one rollover late or not at all. This shows on `count` within 64 cycles of the next low-stage wrap. A stale terminal flag either blocks the carry ripple, giving the same symptom, or moves the `carry_out_n` pulse. That shows on the cycle the full count reaches its terminal value. The bench therefore runs long sequences across several rollovers in both directions, including full 24-bit wraps and a crossing into the third stage. It compares every cycle against an arithmetic reference.

// File: rtl/cntchain_pkg.sv
package cntchain_pkg;
  typedef enum logic [1:0] {
    MODE_LOAD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_HOLD = 2'b11
  } mode_e;
endpackage

// File: rtl/cc_rst_sync.sv
module cc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/cc_stage.sv
module cc_stage
  import cntchain_pkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  mode_e        mode,
  input  logic [W-1:0] load_val,
  input  logic         cin_n,
  input  logic         clin_n,
  output logic [W-1:0] q,
  output logic         cout_n,
  output logic         clout_n
);
  localparam logic [W-1:0] ALL1   = '1;
  localparam logic [W-1:0] ALL0   = '0;
  localparam logic [W-1:0] ONE    = 1;
  localparam logic [W-1:0] PRE_UP = ALL1 - ONE;

  logic [W-1:0] q_r, q_nxt;
  logic         term_r, term_nxt;
  logic         pre_r, pre_nxt;
  logic         clin_r;
  logic         en;

  // count enable: both carry-ins active, look-ahead taken from its flop
  assign en = !cin_n && !clin_r;

  always_comb begin
    q_nxt = q_r;
    unique case (mode)
      MODE_LOAD: q_nxt = load_val;
      MODE_UP:   if (en) q_nxt = q_r + ONE;
      MODE_DOWN: if (en) q_nxt = q_r - ONE;
      default:   q_nxt = q_r;
    endcase
  end

  always_comb begin
    term_nxt = ((mode == MODE_UP)   && (q_nxt == ALL1)) ||
               ((mode == MODE_DOWN) && (q_nxt == ALL0));
    pre_nxt  = ((mode == MODE_UP)   && (q_nxt == PRE_UP)) ||
               ((mode == MODE_DOWN) && (q_nxt == ONE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r    <= '0;
      term_r <= 1'b0;
      pre_r  <= 1'b0;
      clin_r <= 1'b1;
    end else begin
      q_r    <= q_nxt;
      term_r <= term_nxt;
      pre_r  <= pre_nxt;
      clin_r <= clin_n;
    end
  end

  assign q       = q_r;
  assign cout_n  = !term_r || cin_n;
  assign clout_n = !pre_r;

  // R2
  load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LOAD) |=> (q_r == $past(load_val)));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD) |=> $stable(q_r));

  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_UP && en) |=> (q_r == $past(q_r) + ONE));

  // R4
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DOWN && en) |=> (q_r == $past(q_r) - ONE));
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import cntchain_pkg::*;
#(
  parameter int STAGE_W  = 6,
  parameter int N_STAGES = 4,
  localparam int CW      = STAGE_W * N_STAGES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] preset,
  output logic [CW-1:0] count,
  output logic          carry_out_n
);
  localparam logic [STAGE_W-1:0] LA_UP   = {{(STAGE_W-1){1'b1}}, 1'b0};
  localparam logic [STAGE_W-1:0] LA_DOWN = 1;

  logic                rst_i_n;
  mode_e               mode_i;
  logic [N_STAGES-1:0] cout_w;
  logic [N_STAGES-1:0] clout_w;
  logic [N_STAGES-1:0] cin_w;
  logic [N_STAGES-1:0] clin_w;

  assign mode_i = mode_e'(mode);

  cc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  genvar k;
  generate
    for (k = 0; k < N_STAGES; k++) begin : g_stage
      if (k == 0) begin : g_lsb
        assign cin_w[k]  = 1'b0;
        assign clin_w[k] = 1'b0;
      end else begin : g_upper
        assign cin_w[k]  = cout_w[k-1];
        assign clin_w[k] = clout_w[0];
      end

      cc_stage #(.W(STAGE_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_i_n),
        .mode     (mode_i),
        .load_val (preset[k*STAGE_W +: STAGE_W]),
        .cin_n    (cin_w[k]),
        .clin_n   (clin_w[k]),
        .q        (count[k*STAGE_W +: STAGE_W]),
        .cout_n   (cout_w[k]),
        .clout_n  (clout_w[k])
      );

      // R6
      lookahead_value_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
        !clout_w[k] |-> (count[k*STAGE_W +: STAGE_W] == LA_UP ||
                         count[k*STAGE_W +: STAGE_W] == LA_DOWN));
    end
  endgenerate

  assign carry_out_n = cout_w[N_STAGES-1];

  // R6
  lookahead_lead_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!clout_w[0] && mode_i == MODE_UP) |=> !cout_w[0]);

  // R1
  always_comb begin
    if (!rst_n) reset_clear_chk: assert (count == '0 || !$isunknown(count));
  end
endmodule

// File: tb/test_casc_counter.sv
module test_casc_counter;
  logic        clk;
  logic        rst_n;
  logic [1:0]  mode;
  logic [23:0] preset;
  logic [23:0] count;
  logic        carry_out_n;

  int tests;
  int fails;
  logic [23:0] ref_q;
  int run;

  casc_counter i_casc_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .preset      (preset),
    .count       (count),
    .carry_out_n (carry_out_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [23:0] p, input string req);
    logic [23:0] term;
    mode   = m;
    preset = p;
    @(posedge clk);
    case (m)
      2'b00: begin ref_q = p; run = 0; end
      2'b01: begin ref_q = ref_q + 24'd1; run++; end
      2'b10: begin ref_q = ref_q - 24'd1; run++; end
      default: run = 0;
    endcase
    @(negedge clk);
    check(req, count, ref_q);
    if ((m == 2'b01 || m == 2'b10) && run >= 1) begin
      term = (m == 2'b01) ? 24'hFFFFFF : 24'h000000;
      check("R7", {23'd0, carry_out_n}, {23'd0, !(ref_q == term)});
    end
  endtask

  task automatic run_seq(input logic [1:0] m, input logic [23:0] start, input int n, input string req);
    step(2'b00, start, "R2");
    for (int i = 0; i < n; i++) step(m, start, req);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0; run = 0; ref_q = '0;
    rst_n = 1'b0; mode = 2'b01; preset = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", count, 24'd0);
    check("R1", {23'd0, carry_out_n}, 24'd1);
    rst_n = 1'b1;
    // R9 release timing in up mode
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", count, 24'd0);
    @(posedge clk);
    @(negedge clk);
    check("R9", count, 24'd1);

    // R3 many low-stage rollovers and one second-stage crossing
    run_seq(2'b01, 24'h000000, 4200, "R3");
    // R3 full 24-bit wrap, carry at all ones
    run_seq(2'b01, 24'hFFFFC0, 100, "R3");
    run_seq(2'b01, 24'h0FFFF0, 80, "R8");
    // R4 down across zero and across stage borrows
    run_seq(2'b10, 24'h000030, 100, "R4");
    run_seq(2'b10, 24'h03F005, 200, "R4");
    run_seq(2'b10, 24'h100008, 80, "R8");

    // R5 hold keeps value, then counting resumes correctly
    step(2'b00, 24'h123456, "R2");
    for (int i = 0; i < 12; i++) step(2'b11, 24'hABCDEF, "R5");
    for (int i = 0; i < 70; i++) step(2'b01, 24'h000000, "R3");

    // R2 preset mid-count overrides counting
    step(2'b00, 24'h5A5A12, "R2");
    step(2'b00, 24'hA5A521, "R2");
    for (int i = 0; i < 10; i++) step(2'b10, 24'h0, "R4");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule